// File: doc/BRIEF.md
# Dual-Issue Pairing and Branch Gate

This block sits between a two-wide decoder and the execution dispatch port of a small in-order, non-speculative processor. In every cycle it inspects an older and a younger decoded descriptor side by side. Each descriptor carries a valid bit, a branch flag, a predicted-taken flag, one destination register, two source registers and an identifying tag. The block decides whether both descriptors, only the older one, or neither may issue. It reports that count to the decoder in the same cycle, so the decoder knows how far to advance. A younger descriptor that is held back is presented again as the older one in the next cycle.

Issued descriptors land in a two-lane output register that drives dispatch. Because the machine never executes speculatively, anything issued behind an unresolved branch sits in that register with its dispatch flag low until the branch's execution unit reports the outcome. A correct outcome releases the held work. A misprediction discards it and raises a one-cycle fetch redirect carrying the corrected address. A predicted-taken branch also costs one empty issue cycle, because the target cannot arrive in the same cycle as the branch. A downstream stall freezes everything in place.

Top module: `pair_issue_gate`

## Requirements
- R1: When both slots are valid and independent, the consume count is 2 in that cycle. In the following cycle both dispatch flags are high, with the older descriptor on lane 0 and the younger on lane 1. When the older slot is invalid, the consume count is 0.
- R2: If the younger slot reads (source 1 or source 2) the nonzero destination of the older slot, only the older one issues (consume count 1).
- R3: Register number 0 as the older slot's destination never causes the younger slot to be held back.
- R4: When the older slot is a branch, the younger slot never issues in that cycle (consume count at most 1).
- R5: In the cycle after a predicted-taken branch issues, the consume count is 0 even with valid inputs.
- R6: Descriptors issued while a branch is unresolved keep their dispatch flags low until a resolve pulse. They dispatch in the cycle after a correct resolve. The consume count is 0 while they are held and during the resolve cycle.
- R7: A resolve pulse with the mispredict flag set discards all held descriptors, so they are never dispatched. In the next cycle the block raises the redirect flag for one cycle with the resolve address, and the consume count is 0 in that cycle.
- R8: While the stall input is high, the consume count is 0. Dispatch lanes keep their valid flags and tags. No descriptor is lost or dispatched twice.
- R9: During and right after reset, both dispatch flags and the redirect flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Downstream stall; freezes issue and dispatch |
| s0_valid_i | input | 1 | Older slot holds a descriptor |
| s0_branch_i | input | 1 | Older slot is a branch |
| s0_pred_taken_i | input | 1 | Older-slot branch predicted taken |
| s0_rd_i | input | RAW | Older-slot destination register |
| s0_rs1_i | input | RAW | Older-slot first source register |
| s0_rs2_i | input | RAW | Older-slot second source register |
| s0_tag_i | input | TW | Older-slot identifying tag |
| s1_valid_i | input | 1 | Younger slot holds a descriptor |
| s1_branch_i | input | 1 | Younger slot is a branch |
| s1_pred_taken_i | input | 1 | Younger-slot branch predicted taken |
| s1_rd_i | input | RAW | Younger-slot destination register |
| s1_rs1_i | input | RAW | Younger-slot first source register |
| s1_rs2_i | input | RAW | Younger-slot second source register |
| s1_tag_i | input | TW | Younger-slot identifying tag |
| resolve_i | input | 1 | Outcome pulse for the pending branch |
| resolve_mispredict_i | input | 1 | The resolved branch was mispredicted |
| resolve_addr_i | input | AW | Corrected fetch address |
| consume_o | output | 2 | Descriptors taken this cycle (0, 1 or 2) |
| d0_valid_o | output | 1 | Lane 0 dispatch valid |
| d0_branch_o | output | 1 | Lane 0 is a branch |
| d0_rd_o | output | RAW | Lane 0 destination |
| d0_rs1_o | output | RAW | Lane 0 first source |
| d0_rs2_o | output | RAW | Lane 0 second source |
| d0_tag_o | output | TW | Lane 0 tag |
| d1_valid_o | output | 1 | Lane 1 dispatch valid |
| d1_branch_o | output | 1 | Lane 1 is a branch |
| d1_rd_o | output | RAW | Lane 1 destination |
| d1_rs1_o | output | RAW | Lane 1 first source |
| d1_rs2_o | output | RAW | Lane 1 second source |
| d1_tag_o | output | TW | Lane 1 tag |
| redirect_valid_o | output | 1 | One-cycle fetch redirect request |
| redirect_addr_o | output | AW | Redirect target address |

## Verification
A pending-branch flag stuck high shows up at the ports within a cycle or two: dispatch flags stay low after a correct resolve, or the consume count stays at 0 for good. A pending flag that is lost lets post-branch work dispatch before the resolve pulse. A hold lane whose valid bit survives a mispredict shows as a wrong-path tag at dispatch in the cycle after the redirect. A bubble flag that fails to set shows a nonzero consume count one cycle after a taken branch issues. Duplicated or dropped descriptors during a stall change the tag order that the scoreboard sees within a few cycles.

// File: rtl/pig_pkg.sv
package pig_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [1:0] {
    TAKE_NONE  = 2'd0,
    TAKE_OLDER = 2'd1,
    TAKE_BOTH  = 2'd2
  } take_e;
endpackage

// File: rtl/pig_pair_check.sv
module pig_pair_check #(
  parameter int unsigned RAW = 5
) (
  input  logic              issue_en,
  input  logic              s0_valid,
  input  logic              s0_branch,
  input  logic              s0_pred_taken,
  input  logic [RAW-1:0]    s0_rd,
  input  logic              s1_valid,
  input  logic              s1_branch,
  input  logic              s1_pred_taken,
  input  logic [RAW-1:0]    s1_rs1,
  input  logic [RAW-1:0]    s1_rs2,
  output logic              take0,
  output logic              take1,
  output pig_pkg::take_e    take,
  output logic              issued_br,
  output logic              issued_taken
);
  import pig_pkg::*;

  logic writes_live;
  logic raw_hit;

  // Both slots are judged in parallel; register zero never links them.
  always_comb begin
    writes_live  = (s0_rd != '0);
    raw_hit      = writes_live && ((s1_rs1 == s0_rd) || (s1_rs2 == s0_rd));
    take0        = issue_en && s0_valid;
    take1        = take0 && s1_valid && !s0_branch && !raw_hit;
    issued_br    = (take0 && s0_branch) || (take1 && s1_branch);
    issued_taken = (take0 && s0_branch && s0_pred_taken) ||
                   (take1 && s1_branch && s1_pred_taken);
    if (take1)      take = TAKE_BOTH;
    else if (take0) take = TAKE_OLDER;
    else            take = TAKE_NONE;
  end
endmodule

// File: rtl/pig_hold_stage.sv
module pig_hold_stage #(
  parameter int unsigned PW = 23
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   stall_i,
  input  logic                                   resolve_i,
  input  logic                                   mispredict_i,
  input  logic                                   pend_q,
  input  logic [pig_pkg::LANES-1:0]              take,
  input  logic [pig_pkg::LANES-1:0]              br_in,
  input  logic [pig_pkg::LANES-1:0][PW-1:0]      pay_in,
  output logic [pig_pkg::LANES-1:0]              disp_v,
  output logic [pig_pkg::LANES-1:0]              disp_br,
  output logic [pig_pkg::LANES-1:0][PW-1:0]      disp_pay,
  output logic                                   hold_busy,
  output logic                                   held_branch
);
  import pig_pkg::*;

  logic [LANES-1:0]         v_q;
  logic [LANES-1:0]         w_q;
  logic [LANES-1:0]         b_q;
  logic [LANES-1:0][PW-1:0] p_q;

  assign hold_busy   = pend_q && |(v_q & w_q);
  assign held_branch = |(v_q & w_q & b_q);
  assign disp_v      = v_q & ~w_q;
  assign disp_br     = b_q;
  assign disp_pay    = p_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[g] <= 1'b0;
        w_q[g] <= 1'b0;
      end else if (!stall_i && !hold_busy) begin
        v_q[g] <= take[g];
        w_q[g] <= pend_q;
      end else if (resolve_i && v_q[g] && w_q[g]) begin
        if (mispredict_i) v_q[g] <= 1'b0;
        else              w_q[g] <= 1'b0;
      end
    end

    // Payload needs no reset: it is only observed under a valid flag.
    always_ff @(posedge clk) begin
      if (!stall_i && !hold_busy) begin
        p_q[g] <= pay_in[g];
        b_q[g] <= br_in[g];
      end
    end
  end
endmodule

// File: rtl/pig_branch_ctrl.sv
module pig_branch_ctrl #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          issue_en,
  input  logic          resolve_i,
  input  logic          mispredict_i,
  input  logic [AW-1:0] resolve_addr_i,
  input  logic          issued_br,
  input  logic          issued_taken,
  input  logic          held_branch,
  output logic          pend_q,
  output logic          bubble_q,
  output logic          redir_q,
  output logic [AW-1:0] redir_addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      bubble_q <= 1'b0;
      redir_q  <= 1'b0;
    end else begin
      if (resolve_i)                  pend_q <= !mispredict_i && held_branch;
      else if (issue_en && issued_br) pend_q <= 1'b1;

      if (resolve_i && mispredict_i)  bubble_q <= 1'b0;
      else if (adv)                   bubble_q <= issue_en && issued_taken;

      redir_q <= resolve_i && mispredict_i;
    end
  end

  always_ff @(posedge clk) begin
    if (resolve_i) redir_addr_q <= resolve_addr_i;
  end
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int unsigned RAW = 5,
  parameter int unsigned TW  = 8,
  parameter int unsigned AW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stall_i,
  input  logic           s0_valid_i,
  input  logic           s0_branch_i,
  input  logic           s0_pred_taken_i,
  input  logic [RAW-1:0] s0_rd_i,
  input  logic [RAW-1:0] s0_rs1_i,
  input  logic [RAW-1:0] s0_rs2_i,
  input  logic [TW-1:0]  s0_tag_i,
  input  logic           s1_valid_i,
  input  logic           s1_branch_i,
  input  logic           s1_pred_taken_i,
  input  logic [RAW-1:0] s1_rd_i,
  input  logic [RAW-1:0] s1_rs1_i,
  input  logic [RAW-1:0] s1_rs2_i,
  input  logic [TW-1:0]  s1_tag_i,
  input  logic           resolve_i,
  input  logic           resolve_mispredict_i,
  input  logic [AW-1:0]  resolve_addr_i,
  output logic [1:0]     consume_o,
  output logic           d0_valid_o,
  output logic           d0_branch_o,
  output logic [RAW-1:0] d0_rd_o,
  output logic [RAW-1:0] d0_rs1_o,
  output logic [RAW-1:0] d0_rs2_o,
  output logic [TW-1:0]  d0_tag_o,
  output logic           d1_valid_o,
  output logic           d1_branch_o,
  output logic [RAW-1:0] d1_rd_o,
  output logic [RAW-1:0] d1_rs1_o,
  output logic [RAW-1:0] d1_rs2_o,
  output logic [TW-1:0]  d1_tag_o,
  output logic           redirect_valid_o,
  output logic [AW-1:0]  redirect_addr_o
);
  import pig_pkg::*;

  localparam int unsigned PW = 3 * RAW + TW;

  logic                      adv;
  logic                      issue_en;
  logic                      take0;
  logic                      take1;
  take_e                     take_w;
  logic                      issued_br;
  logic                      issued_taken;
  logic                      pend_q;
  logic                      bubble_q;
  logic                      redir_q;
  logic                      hold_busy;
  logic                      held_branch;
  logic [LANES-1:0]          disp_v;
  logic [LANES-1:0]          disp_br;
  logic [LANES-1:0][PW-1:0]  pay_in;
  logic [LANES-1:0][PW-1:0]  disp_pay;

  // An issue slot exists only when nothing downstream or in the branch path blocks it.
  assign adv      = !stall_i && !hold_busy && !resolve_i && !redir_q;
  assign issue_en = adv && !bubble_q;

  pig_pair_check #(.RAW(RAW)) pair_i (
    .issue_en      (issue_en),
    .s0_valid      (s0_valid_i),
    .s0_branch     (s0_branch_i),
    .s0_pred_taken (s0_pred_taken_i),
    .s0_rd         (s0_rd_i),
    .s1_valid      (s1_valid_i),
    .s1_branch     (s1_branch_i),
    .s1_pred_taken (s1_pred_taken_i),
    .s1_rs1        (s1_rs1_i),
    .s1_rs2        (s1_rs2_i),
    .take0         (take0),
    .take1         (take1),
    .take          (take_w),
    .issued_br     (issued_br),
    .issued_taken  (issued_taken)
  );

  assign pay_in[0] = {s0_rd_i, s0_rs1_i, s0_rs2_i, s0_tag_i};
  assign pay_in[1] = {s1_rd_i, s1_rs1_i, s1_rs2_i, s1_tag_i};

  pig_hold_stage #(.PW(PW)) hold_i (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .resolve_i    (resolve_i),
    .mispredict_i (resolve_mispredict_i),
    .pend_q       (pend_q),
    .take         ({take1, take0}),
    .br_in        ({s1_branch_i, s0_branch_i}),
    .pay_in       (pay_in),
    .disp_v       (disp_v),
    .disp_br      (disp_br),
    .disp_pay     (disp_pay),
    .hold_busy    (hold_busy),
    .held_branch  (held_branch)
  );

  pig_branch_ctrl #(.AW(AW)) brc_i (
    .clk            (clk),
    .rst            (rst),
    .adv            (adv),
    .issue_en       (issue_en),
    .resolve_i      (resolve_i),
    .mispredict_i   (resolve_mispredict_i),
    .resolve_addr_i (resolve_addr_i),
    .issued_br      (issued_br),
    .issued_taken   (issued_taken),
    .held_branch    (held_branch),
    .pend_q         (pend_q),
    .bubble_q       (bubble_q),
    .redir_q        (redir_q),
    .redir_addr_q   (redirect_addr_o)
  );

  assign consume_o        = take_w;
  assign redirect_valid_o = redir_q;
  assign d0_valid_o       = disp_v[0];
  assign d1_valid_o       = disp_v[1];
  assign d0_branch_o      = disp_br[0];
  assign d1_branch_o      = disp_br[1];
  assign {d0_rd_o, d0_rs1_o, d0_rs2_o, d0_tag_o} = disp_pay[0];
  assign {d1_rd_o, d1_rs1_o, d1_rs2_o, d1_tag_o} = disp_pay[1];
endmodule

// File: rtl/pair_issue_gate_chk.sv
module pair_issue_gate_chk #(
  parameter int unsigned RAW = 5,
  parameter int unsigned TW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           stall_i,
  input logic           resolve_i,
  input logic           resolve_mispredict_i,
  input logic           s0_valid_i,
  input logic           s0_branch_i,
  input logic           s0_pred_taken_i,
  input logic [RAW-1:0] s0_rd_i,
  input logic           s1_valid_i,
  input logic [RAW-1:0] s1_rs1_i,
  input logic [RAW-1:0] s1_rs2_i,
  input logic [1:0]     consume_o,
  input logic           d0_valid_o,
  input logic [TW-1:0]  d0_tag_o,
  input logic           d1_valid_o,
  input logic [TW-1:0]  d1_tag_o,
  input logic           redirect_valid_o
);
  a_r2_raw_holds_younger: assert property (@(posedge clk) disable iff (rst)
    (s0_valid_i && s1_valid_i && s0_rd_i != '0 &&
     (s1_rs1_i == s0_rd_i || s1_rs2_i == s0_rd_i)) |-> consume_o != 2'd2);

  a_r4_branch_nulls_younger: assert property (@(posedge clk) disable iff (rst)
    (s0_valid_i && s0_branch_i) |-> consume_o != 2'd2);

  a_r5_taken_bubble: assert property (@(posedge clk) disable iff (rst)
    (consume_o != 2'd0 && s0_branch_i && s0_pred_taken_i) |=> consume_o == 2'd0);

  a_r6_no_issue_on_resolve: assert property (@(posedge clk) disable iff (rst)
    resolve_i |-> consume_o == 2'd0);

  a_r7_redirect_follows: assert property (@(posedge clk) disable iff (rst)
    (resolve_i && resolve_mispredict_i) |=> (redirect_valid_o && consume_o == 2'd0));

  a_r8_stall_no_take: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> consume_o == 2'd0);

  a_r8_stall_freezes_lanes: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !resolve_i) |=> ($stable(d0_valid_o) && $stable(d0_tag_o) &&
                                 $stable(d1_valid_o) && $stable(d1_tag_o)));
endmodule

bind pair_issue_gate pair_issue_gate_chk #(.RAW(RAW), .TW(TW)) chk_i (.*);

// File: tb/pair_issue_gate_tb_top.sv
`timescale 1ns/1ps
module pair_issue_gate_tb_top;
  localparam int RAW = 5;
  localparam int TW  = 8;
  localparam int AW  = 16;
  localparam int PN  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           stall_i = 0;
  logic           s0_valid_i = 0, s0_branch_i = 0, s0_pred_taken_i = 0;
  logic [RAW-1:0] s0_rd_i = 0, s0_rs1_i = 0, s0_rs2_i = 0;
  logic [TW-1:0]  s0_tag_i = 0;
  logic           s1_valid_i = 0, s1_branch_i = 0, s1_pred_taken_i = 0;
  logic [RAW-1:0] s1_rd_i = 0, s1_rs1_i = 0, s1_rs2_i = 0;
  logic [TW-1:0]  s1_tag_i = 0;
  logic           resolve_i = 0, resolve_mispredict_i = 0;
  logic [AW-1:0]  resolve_addr_i = 0;
  logic [1:0]     consume_o;
  logic           d0_valid_o, d0_branch_o, d1_valid_o, d1_branch_o;
  logic [RAW-1:0] d0_rd_o, d0_rs1_o, d0_rs2_o, d1_rd_o, d1_rs1_o, d1_rs2_o;
  logic [TW-1:0]  d0_tag_o, d1_tag_o;
  logic           redirect_valid_o;
  logic [AW-1:0]  redirect_addr_o;

  pair_issue_gate #(.RAW(RAW), .TW(TW), .AW(AW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;
  int exp_q[$];

  // program image presented by the bench-side decoder
  bit       p_v[PN], p_br[PN], p_tk[PN], p_mis[PN];
  int       p_rd[PN], p_rs1[PN], p_rs2[PN], p_tgt[PN];

  int exp_cons[$];
  int exp_nd[$];
  bit redir_log[PN];
  int raddr_log[PN];
  bit d0v_log[PN];
  int d0tag_log[PN];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < PN; i++) begin
      p_v[i] = 0; p_br[i] = 0; p_tk[i] = 0; p_mis[i] = 0;
      p_rd[i] = 0; p_rs1[i] = 0; p_rs2[i] = 0; p_tgt[i] = 0;
    end
  endtask

  task automatic put(input int i, input bit br, input bit tk, input bit mis,
                     input int rd, input int rs1, input int rs2, input int tgt);
    p_v[i] = 1; p_br[i] = br; p_tk[i] = tk; p_mis[i] = mis;
    p_rd[i] = rd; p_rs1[i] = rs1; p_rs2[i] = rs2; p_tgt[i] = tgt;
  endtask

  task automatic drive_slots(input int ptr);
    bit ok0, ok1;
    ok0 = (ptr < PN) && p_v[ptr];
    ok1 = (ptr + 1 < PN) && p_v[ptr+1];
    s0_valid_i = ok0;
    s0_branch_i = ok0 && p_br[ptr];
    s0_pred_taken_i = ok0 && p_tk[ptr];
    s0_rd_i  = ok0 ? RAW'(p_rd[ptr])  : '0;
    s0_rs1_i = ok0 ? RAW'(p_rs1[ptr]) : '0;
    s0_rs2_i = ok0 ? RAW'(p_rs2[ptr]) : '0;
    s0_tag_i = TW'(ptr);
    s1_valid_i = ok1;
    s1_branch_i = ok1 && p_br[ptr+1];
    s1_pred_taken_i = ok1 && p_tk[ptr+1];
    s1_rd_i  = ok1 ? RAW'(p_rd[ptr+1])  : '0;
    s1_rs1_i = ok1 ? RAW'(p_rs1[ptr+1]) : '0;
    s1_rs2_i = ok1 ? RAW'(p_rs2[ptr+1]) : '0;
    s1_tag_i = TW'(ptr + 1);
  endtask

  task automatic reset_dut();
    rst = 1;
    drive_slots(PN);
    stall_i = 0; resolve_i = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  // Decoder model plus resolve generator; checks consume and accepted dispatches per cycle.
  task automatic run(input int dly, input logic [31:0] smask, input string reqs);
    int ptr = 0;
    int res_at = -1;
    int res_tag = 0;
    int cons, nd;
    mon_on = 1;
    for (int c = 0; c < exp_cons.size(); c++) begin
      drive_slots(ptr);
      stall_i = smask[c];
      resolve_i = (c == res_at);
      resolve_mispredict_i = (c == res_at) && p_mis[res_tag];
      resolve_addr_i = AW'(p_tgt[res_tag]);
      @(negedge clk);
      cons = int'(consume_o);
      nd = int'(d0_valid_o && !stall_i) + int'(d1_valid_o && !stall_i);
      if (d0_valid_o && d0_branch_o && !stall_i) begin res_at = c + dly; res_tag = int'(d0_tag_o); end
      if (d1_valid_o && d1_branch_o && !stall_i) begin res_at = c + dly; res_tag = int'(d1_tag_o); end
      redir_log[c] = redirect_valid_o;
      raddr_log[c] = int'(redirect_addr_o);
      d0v_log[c]   = d0_valid_o;
      d0tag_log[c] = int'(d0_tag_o);
      chk(cons == exp_cons[c], $sformatf("%s consume in cycle %0d", reqs, c), cons, exp_cons[c]);
      chk(nd == exp_nd[c], $sformatf("%s dispatch count in cycle %0d", reqs, c), nd, exp_nd[c]);
      @(posedge clk);
      #1;
      ptr += cons;
      if (redir_log[c]) ptr = raddr_log[c];
    end
    drive_slots(PN);
    stall_i = 0; resolve_i = 0; resolve_mispredict_i = 0;
    @(negedge clk);
    mon_on = 0;
    chk(exp_q.size() == 0, {reqs, " scoreboard left undispatched items"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Scoreboard monitor: every accepted dispatch must match program order.
  task automatic pop_cmp(input int tag);
    int e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R1 R7 R8 scoreboard: unexpected dispatch tag actual %0d expected none", tag);
    end else begin
      e = exp_q.pop_front();
      if (e != tag) begin
        fails++;
        $display("FAIL R1 R7 R8 scoreboard order: actual %0d expected %0d", tag, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mon_on) begin
      if (d0_valid_o && !stall_i) pop_cmp(int'(d0_tag_o));
      if (d1_valid_o && !stall_i) pop_cmp(int'(d1_tag_o));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual hung expected completion");
    finish_run();
  end

  initial begin
    clear_prog();
    drive_slots(PN);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(!d0_valid_o, "R9 lane 0 valid in reset", int'(d0_valid_o), 0);
    chk(!d1_valid_o, "R9 lane 1 valid in reset", int'(d1_valid_o), 0);
    chk(!redirect_valid_o, "R9 redirect in reset", int'(redirect_valid_o), 0);
    @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!d0_valid_o && !d1_valid_o, "R9 lanes idle after reset", int'(d0_valid_o) + int'(d1_valid_o), 0);
    chk(consume_o == 2'd0, "R1 consume with invalid older slot", int'(consume_o), 0);

    // Pairing: independent pair, RAW hazard, register zero
    clear_prog();
    put(0, 0, 0, 0, 1, 2, 3, 0);
    put(1, 0, 0, 0, 4, 2, 3, 0);
    put(2, 0, 0, 0, 5, 1, 1, 0);
    put(3, 0, 0, 0, 6, 5, 0, 0);
    put(4, 0, 0, 0, 9, 1, 2, 0);
    put(5, 0, 0, 0, 0, 1, 1, 0);
    put(6, 0, 0, 0, 8, 0, 0, 0);
    exp_q = '{0, 1, 2, 3, 4, 5, 6};
    exp_cons = '{2, 1, 2, 2, 0};
    exp_nd   = '{0, 2, 1, 2, 2};
    reset_dut();
    run(3, 32'h0, "R1 R2 R3");

    // Taken branch in the younger slot, then a not-taken branch in the older slot
    clear_prog();
    put(0, 0, 0, 0, 1, 4, 4, 0);
    put(1, 1, 1, 0, 0, 2, 3, 2);
    put(2, 0, 0, 0, 2, 7, 7, 0);
    put(3, 0, 0, 0, 3, 7, 7, 0);
    put(4, 1, 0, 0, 0, 1, 1, 0);
    put(5, 0, 0, 0, 10, 1, 1, 0);
    put(6, 0, 0, 0, 11, 10, 2, 0);
    exp_q = '{0, 1, 2, 3, 4, 5, 6};
    exp_cons = '{2, 0, 2, 0, 0, 1, 1, 0, 0, 0, 1, 0};
    exp_nd   = '{0, 2, 0, 0, 0, 2, 1, 0, 0, 0, 1, 1};
    reset_dut();
    run(3, 32'h0, "R4 R5 R6");

    // Mispredicted taken branch: wrong-path work discarded, redirect to index 4
    clear_prog();
    put(0, 1, 1, 1, 0, 1, 2, 4);
    put(1, 0, 0, 0, 1, 3, 3, 0);
    put(2, 0, 0, 0, 2, 3, 3, 0);
    put(3, 0, 0, 0, 3, 3, 3, 0);
    put(4, 0, 0, 0, 3, 6, 6, 0);
    put(5, 0, 0, 0, 4, 6, 6, 0);
    exp_q = '{0, 4, 5};
    exp_cons = '{1, 0, 2, 0, 0, 2, 0};
    exp_nd   = '{0, 1, 0, 0, 0, 0, 2};
    reset_dut();
    run(2, 32'h0, "R4 R5 R7");
    chk(!redir_log[3], "R7 redirect early", int'(redir_log[3]), 0);
    chk(redir_log[4], "R7 redirect flag after mispredict", int'(redir_log[4]), 1);
    chk(raddr_log[4] == 4, "R7 redirect address", raddr_log[4], 4);
    chk(!redir_log[5], "R7 redirect lasts one cycle", int'(redir_log[5]), 0);

    // Downstream stall for two cycles while a pair waits at dispatch
    clear_prog();
    put(0, 0, 0, 0, 1, 0, 0, 0);
    put(1, 0, 0, 0, 2, 0, 0, 0);
    put(2, 0, 0, 0, 3, 0, 0, 0);
    put(3, 0, 0, 0, 4, 0, 0, 0);
    exp_q = '{0, 1, 2, 3};
    exp_cons = '{2, 0, 0, 2, 0};
    exp_nd   = '{0, 0, 0, 2, 2};
    reset_dut();
    run(3, 32'h6, "R1 R8");
    chk(d0v_log[1] && d0v_log[2], "R8 lane 0 valid held through stall",
        int'(d0v_log[1]) + int'(d0v_log[2]), 2);
    chk(d0tag_log[2] == 0, "R8 lane 0 tag frozen during stall", d0tag_log[2], 0);

    finish_run();
  end
endmodule